// File: doc/BRIEF.md
# Coprocessor Shared-RAM Register Window

This block gives a host a small register window into the private RAM of an I/O coprocessor. The RAM is never mapped directly. The host first loads a 16-bit pointer as two separate byte writes, low byte and high byte. It then moves bytes one at a time through a single data register. When auto-increment is enabled, each data access advances the pointer by one. A whole code image can then be uploaded, read back or compared after a single pointer load.

A control/status register holds four host controls:
- a run enable that keeps the coprocessor going;
- the auto-increment enable;
- a serial pass-through enable;
- a doorbell that tells the coprocessor a mailbox changed.

The same register also holds two sticky event flags raised by the coprocessor: one for completed outgoing messages and one for new incoming messages. Both flags drive a single host interrupt line. The host clears a flag by writing a one to its bit, usually together with run and auto-increment. The coprocessor reaches the same byte-wide RAM through a request/grant port. The RAM is single-ported and host data accesses take priority.

Top module: `coproc_ram_window`

## Requirements
- R1: After synchronous reset, the pointer is 0x0000, the control register reads 0x00, and `host_irq`, `cp_run`, `serial_bypass` and `cp_doorbell` are all 0.
- R2: Register select 0 loads the pointer's low byte and select 1 loads its high byte. Each write leaves the other byte unchanged. Reading selects 0 and 1 returns the current pointer bytes.
- R3: Register select 2 is the data port. A write stores `bus_wdata` at the current pointer. A read returns the byte stored at the current pointer on `bus_rdata` in the cycle after the read strobe. All register reads have that one-cycle latency.
- R4: With auto-increment clear (control bit 1 = 0), data reads and writes leave the pointer unchanged.
- R5: With auto-increment set, every data read or write uses the current pointer and then advances it by one. The pointer wraps from 0xFFFF to 0x0000.
- R6: Register select 3 is the control register. Bit 0 (run), bit 1 (auto-increment) and bit 2 (pass-through) take the written value directly. `cp_run` and `serial_bypass` follow bits 0 and 2 from the cycle after the write. Reads return these bits in place, with bits 7:6 reading 0.
- R7: Writing 1 to control bit 3 raises `cp_doorbell`, and writing 0 there has no effect. A `cp_doorbell_ack` pulse lowers it, but a host set in the same cycle wins over the acknowledge.
- R8: A pulse on `int0_set` sets flag bit 4, and a pulse on `int1_set` sets flag bit 5. The host clears a flag by writing 1 to its bit. Writing 0 leaves the flag unchanged.
- R9: If a set strobe and a host write-one-to-clear of the same flag fall in the same cycle, the flag ends up set.
- R10: `host_irq` is high exactly when at least one of the two flags is set.
- R11: The RAM holds 2^MEM_AW bytes (1024 by default) and uses the low MEM_AW pointer bits, so pointer 0xFFFF aliases byte 0x3FF. Host data accesses win the RAM: `cp_gnt` is low in any cycle with a host data access. A granted coprocessor write stores its byte. A granted coprocessor read returns its byte on `cp_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Host register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid the cycle after a read strobe |
| host_irq | output | 1 | OR of the two event flags |
| cp_run | output | 1 | Run enable to the coprocessor |
| serial_bypass | output | 1 | Serial pass-through enable |
| cp_doorbell | output | 1 | Host-to-coprocessor doorbell |
| cp_doorbell_ack | input | 1 | Coprocessor acknowledge, clears the doorbell |
| int0_set | input | 1 | Coprocessor strobe that sets event flag 0 |
| int1_set | input | 1 | Coprocessor strobe that sets event flag 1 |
| cp_req | input | 1 | Coprocessor RAM request |
| cp_we | input | 1 | Coprocessor RAM write enable |
| cp_addr | input | MEM_AW | Coprocessor RAM byte address |
| cp_wdata | input | 8 | Coprocessor RAM write data |
| cp_gnt | output | 1 | Coprocessor request accepted this cycle |
| cp_rdata | output | 8 | Coprocessor read data, valid the cycle after a granted read |

## Verification
Register writes, pointer steps, flag sets and clears, and doorbell changes all take effect at the clock edge that ends the strobe cycle. The bench reads them back through a later access or samples the outputs at the following falling edge. Host read data goes through one register, so `bus_rdata` is sampled at the falling edge one cycle after the read strobe. Coprocessor read data is sampled the same way, one cycle after its grant. `cp_gnt` is combinational and is sampled inside the request cycle, just after the inputs settle. Same-cycle races are driven together in one cycle and judged by a later read of the control register: set against clear, and doorbell set against acknowledge.

// File: rtl/crw_pkg.sv
package crw_pkg;

    localparam int PTR_W = 16;

    typedef enum logic [1:0] {
        SEL_PTR_LO = 2'd0,
        SEL_PTR_HI = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_CTRL   = 2'd3
    } crw_sel_e;

    // Control register image, bit 0 at the bottom.
    typedef struct packed {
        logic ev1;       // bit 5
        logic ev0;       // bit 4
        logic doorbell;  // bit 3
        logic bypass;    // bit 2
        logic autoinc;   // bit 1
        logic run;       // bit 0
    } crw_ctrl_t;

    localparam int BIT_RUN     = 0;
    localparam int BIT_AUTOINC = 1;
    localparam int BIT_BYPASS  = 2;
    localparam int BIT_DBELL   = 3;
    localparam int BIT_EV0     = 4;
    localparam int BIT_EV1     = 5;

    typedef struct packed {
        logic ld_lo;
        logic ld_hi;
        logic dat_wr;
        logic dat_rd;
        logic ctl_wr;
        logic any_rd;
    } crw_dec_t;

    function automatic crw_dec_t crw_decode(input logic en, input logic we,
                                            input crw_sel_e sel);
        crw_dec_t d;
        d.ld_lo  = en &&  we && (sel == SEL_PTR_LO);
        d.ld_hi  = en &&  we && (sel == SEL_PTR_HI);
        d.dat_wr = en &&  we && (sel == SEL_DATA);
        d.dat_rd = en && !we && (sel == SEL_DATA);
        d.ctl_wr = en &&  we && (sel == SEL_CTRL);
        d.any_rd = en && !we;
        return d;
    endfunction

    function automatic logic [7:0] crw_ctrl_byte(input crw_ctrl_t c);
        return {2'b00, c};
    endfunction

endpackage

// File: rtl/crw_ptr_ctr.sv
module crw_ptr_ctr
    import crw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       wdata,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - 8;

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ld_lo) begin
            ptr_q[7:0] <= wdata;
        end else if (ld_hi) begin
            ptr_q[PTR_W-1:8] <= wdata[HI_W-1:0];
        end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_lo && !ld_hi) |=> (ptr == $past(ptr) + 1'b1)); // R5

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld_lo && !ld_hi) |=> $stable(ptr)); // R4

    AST_PTR_LO_KEEP_HI: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> (ptr[PTR_W-1:8] == $past(ptr[PTR_W-1:8]))); // R2

endmodule

// File: rtl/crw_ctrl_flags.sv
module crw_ctrl_flags
    import crw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       ev0_set,
    input  logic       ev1_set,
    input  logic       dbell_ack,
    output crw_ctrl_t  ctrl
);
    crw_ctrl_t ctrl_q, ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.run     = wdata[BIT_RUN];
            ctrl_d.autoinc = wdata[BIT_AUTOINC];
            ctrl_d.bypass  = wdata[BIT_BYPASS];
        end
        // Doorbell: host set beats coprocessor acknowledge.
        ctrl_d.doorbell = (wr && wdata[BIT_DBELL]) || (ctrl_q.doorbell && !dbell_ack);
        // Event flags: set strobe beats host write-one-to-clear.
        ctrl_d.ev0 = ev0_set || (ctrl_q.ev0 && !(wr && wdata[BIT_EV0]));
        ctrl_d.ev1 = ev1_set || (ctrl_q.ev1 && !(wr && wdata[BIT_EV1]));
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    AST_EV0_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ev0_set |=> ctrl.ev0); // R9

    AST_EV1_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ev1_set |=> ctrl.ev1); // R9

    AST_EV0_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[BIT_EV0] && !ev0_set) |=> !ctrl.ev0); // R8

    AST_EV0_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ev0 && !(wr && wdata[BIT_EV0])) |=> ctrl.ev0); // R8

    AST_DBELL_ACK: assert property (@(posedge clk) disable iff (rst)
        (dbell_ack && !(wr && wdata[BIT_DBELL])) |=> !ctrl.doorbell); // R7

endmodule

// File: rtl/crw_ram_port.sv
module crw_ram_port
    import crw_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [PTR_W-1:0]  host_ptr,
    input  logic [7:0]        host_wdata,
    input  logic              cp_req,
    input  logic              cp_we,
    input  logic [MEM_AW-1:0] cp_addr,
    input  logic [7:0]        cp_wdata,
    output logic              cp_gnt,
    output logic [7:0]        rd_q
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0]        mem [DEPTH];
    logic [MEM_AW-1:0] a_sel;
    logic [7:0]        wd_sel;
    logic              wr_sel;
    logic              rd_sel;
    logic [7:0]        rd_r;

    always_comb begin
        cp_gnt = cp_req && !host_en;
        if (host_en) begin
            a_sel  = host_ptr[MEM_AW-1:0];
            wd_sel = host_wdata;
            wr_sel = host_we;
            rd_sel = !host_we;
        end else begin
            a_sel  = cp_addr;
            wd_sel = cp_wdata;
            wr_sel = cp_gnt && cp_we;
            rd_sel = cp_gnt && !cp_we;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_sel) mem[a_sel] <= wd_sel;
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_r <= '0;
        else if (rd_sel) rd_r <= mem[a_sel];
    end

    assign rd_q = rd_r;

    AST_CP_READ_DATA: assert property (@(posedge clk) disable iff (rst)
        (cp_gnt && !cp_we) |=> (rd_q == mem[$past(cp_addr)])); // R11

    AST_HOST_READ_DATA: assert property (@(posedge clk) disable iff (rst)
        (host_en && !host_we) |=> (rd_q == mem[$past(host_ptr[MEM_AW-1:0])])); // R3

endmodule

// File: rtl/coproc_ram_window.sv
module coproc_ram_window
    import crw_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_reg,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              host_irq,
    output logic              cp_run,
    output logic              serial_bypass,
    output logic              cp_doorbell,
    input  logic              cp_doorbell_ack,
    input  logic              int0_set,
    input  logic              int1_set,
    input  logic              cp_req,
    input  logic              cp_we,
    input  logic [MEM_AW-1:0] cp_addr,
    input  logic [7:0]        cp_wdata,
    output logic              cp_gnt,
    output logic [7:0]        cp_rdata
);
    crw_sel_e         sel;
    crw_dec_t         dec;
    crw_ctrl_t        ctrl;
    logic [PTR_W-1:0] ptr;
    logic             data_acc;
    logic [7:0]       ram_q;
    crw_sel_e         rd_sel_q;
    logic [7:0]       rd_byte_q;

    assign sel      = crw_sel_e'(bus_reg);
    assign dec      = crw_decode(bus_en, bus_we, sel);
    assign data_acc = dec.dat_wr || dec.dat_rd;

    crw_ptr_ctr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .ld_lo (dec.ld_lo),
        .ld_hi (dec.ld_hi),
        .wdata (bus_wdata),
        .step  (data_acc && ctrl.autoinc),
        .ptr   (ptr)
    );

    crw_ctrl_flags u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (dec.ctl_wr),
        .wdata     (bus_wdata),
        .ev0_set   (int0_set),
        .ev1_set   (int1_set),
        .dbell_ack (cp_doorbell_ack),
        .ctrl      (ctrl)
    );

    crw_ram_port #(.MEM_AW(MEM_AW)) u_ram (
        .clk        (clk),
        .rst        (rst),
        .host_en    (data_acc),
        .host_we    (dec.dat_wr),
        .host_ptr   (ptr),
        .host_wdata (bus_wdata),
        .cp_req     (cp_req),
        .cp_we      (cp_we),
        .cp_addr    (cp_addr),
        .cp_wdata   (cp_wdata),
        .cp_gnt     (cp_gnt),
        .rd_q       (ram_q)
    );

    // Register read path: one register stage for every select.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sel_q  <= SEL_PTR_LO;
            rd_byte_q <= '0;
        end else if (dec.any_rd) begin
            rd_sel_q <= sel;
            unique case (sel)
                SEL_PTR_LO: rd_byte_q <= ptr[7:0];
                SEL_PTR_HI: rd_byte_q <= ptr[PTR_W-1:8];
                SEL_CTRL:   rd_byte_q <= crw_ctrl_byte(ctrl);
                default:    rd_byte_q <= rd_byte_q;
            endcase
        end
    end

    assign bus_rdata     = (rd_sel_q == SEL_DATA) ? ram_q : rd_byte_q;
    assign cp_rdata      = ram_q;
    assign host_irq      = ctrl.ev0 || ctrl.ev1;
    assign cp_run        = ctrl.run;
    assign serial_bypass = ctrl.bypass;
    assign cp_doorbell   = ctrl.doorbell;

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        (int0_set || int1_set) |=> host_irq); // R10

    AST_HOST_OWNS_RAM: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_reg == 2'd2) |-> !cp_gnt); // R11

    AST_RUN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_reg == 2'd3) |=> (cp_run == $past(bus_wdata[0]))); // R6

endmodule

// File: tb/tb_coproc_ram_window.sv
module tb_coproc_ram_window;

    localparam int MEM_AW = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_en, bus_we;
    logic [1:0]        bus_reg;
    logic [7:0]        bus_wdata, bus_rdata;
    logic              host_irq, cp_run, serial_bypass, cp_doorbell;
    logic              cp_doorbell_ack, int0_set, int1_set;
    logic              cp_req, cp_we, cp_gnt;
    logic [MEM_AW-1:0] cp_addr;
    logic [7:0]        cp_wdata, cp_rdata;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    coproc_ram_window #(.MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq),
        .cp_run(cp_run), .serial_bypass(serial_bypass), .cp_doorbell(cp_doorbell),
        .cp_doorbell_ack(cp_doorbell_ack), .int0_set(int0_set), .int1_set(int1_set),
        .cp_req(cp_req), .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_gnt(cp_gnt), .cp_rdata(cp_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] r, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_reg = r;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_ptr(output logic [15:0] p);
        logic [7:0] lo, hi;
        rd_reg(2'd0, lo);
        rd_reg(2'd1, hi);
        p = {hi, lo};
    endtask

    task automatic set_ptr(input logic [15:0] p);
        wr_reg(2'd0, p[7:0]);
        wr_reg(2'd1, p[15:8]);
    endtask

    task automatic t_reset;
        logic [7:0] c; logic [15:0] p;
        check("R1", "host_irq", {15'd0, host_irq}, 16'd0);
        check("R1", "run/bypass/doorbell", {13'd0, cp_run, serial_bypass, cp_doorbell}, 16'd0);
        rd_reg(2'd3, c);
        check("R1", "ctrl", {8'd0, c}, 16'h0000);
        rd_ptr(p);
        check("R1", "pointer", p, 16'h0000);
    endtask

    task automatic t_ptr_load;
        logic [15:0] p;
        set_ptr(16'h1234);
        rd_ptr(p);
        check("R2", "pointer load", p, 16'h1234);
        wr_reg(2'd0, 8'h56);
        rd_ptr(p);
        check("R2", "low write keeps high", p, 16'h1256);
        wr_reg(2'd1, 8'h9A);
        rd_ptr(p);
        check("R2", "high write keeps low", p, 16'h9A56);
    endtask

    task automatic t_no_inc;
        logic [15:0] p; logic [7:0] d;
        wr_reg(2'd3, 8'h00);
        set_ptr(16'h0010);
        wr_reg(2'd2, 8'hA5);
        rd_ptr(p);
        check("R4", "pointer after write", p, 16'h0010);
        rd_reg(2'd2, d);
        check("R3", "data readback", {8'd0, d}, 16'h00A5);
        rd_ptr(p);
        check("R4", "pointer after read", p, 16'h0010);
    endtask

    task automatic t_inc;
        logic [15:0] p; logic [7:0] d;
        wr_reg(2'd3, 8'h02);
        set_ptr(16'h0020);
        for (int i = 0; i < 3; i++) wr_reg(2'd2, 8'h11 * (i + 1));
        rd_ptr(p);
        check("R5", "pointer after 3 writes", p, 16'h0023);
        set_ptr(16'h0020);
        for (int i = 0; i < 3; i++) begin
            rd_reg(2'd2, d);
            check("R5", "burst read byte", {8'd0, d}, 16'(8'h11 * (i + 1)));
        end
        rd_ptr(p);
        check("R5", "pointer after 3 reads", p, 16'h0023);
    endtask

    task automatic t_wrap;
        logic [15:0] p; logic [7:0] d;
        wr_reg(2'd3, 8'h02);
        set_ptr(16'hFFFF);
        wr_reg(2'd2, 8'hC3);
        rd_ptr(p);
        check("R5", "wrap to zero", p, 16'h0000);
        wr_reg(2'd3, 8'h00);
        set_ptr(16'h03FF);
        rd_reg(2'd2, d);
        check("R11", "alias of 0xFFFF at 0x3FF", {8'd0, d}, 16'h00C3);
    endtask

    task automatic t_ctrl;
        logic [7:0] c;
        wr_reg(2'd3, 8'h07);
        check("R6", "run/bypass set", {14'd0, cp_run, serial_bypass}, 16'h0003);
        rd_reg(2'd3, c);
        check("R6", "ctrl readback", {8'd0, c}, 16'h0007);
        wr_reg(2'd3, 8'h04);
        check("R6", "run cleared, bypass kept", {14'd0, cp_run, serial_bypass}, 16'h0001);
        wr_reg(2'd3, 8'h00);
    endtask

    task automatic t_doorbell;
        wr_reg(2'd3, 8'h08);
        check("R7", "doorbell set", {15'd0, cp_doorbell}, 16'd1);
        wr_reg(2'd3, 8'h00);
        check("R7", "zero write no effect", {15'd0, cp_doorbell}, 16'd1);
        @(negedge clk); cp_doorbell_ack = 1'b1;
        @(negedge clk); cp_doorbell_ack = 1'b0;
        check("R7", "ack clears", {15'd0, cp_doorbell}, 16'd0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_reg = 2'd3; bus_wdata = 8'h08; cp_doorbell_ack = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; cp_doorbell_ack = 1'b0;
        check("R7", "set beats ack", {15'd0, cp_doorbell}, 16'd1);
        @(negedge clk); cp_doorbell_ack = 1'b1;
        @(negedge clk); cp_doorbell_ack = 1'b0;
    endtask

    task automatic t_flags;
        logic [7:0] c;
        wr_reg(2'd3, 8'h03);
        @(negedge clk); int0_set = 1'b1;
        @(negedge clk); int0_set = 1'b0;
        check("R10", "irq on flag 0", {15'd0, host_irq}, 16'd1);
        rd_reg(2'd3, c);
        check("R8", "flag 0 bit 4", {8'd0, c}, 16'h0013);
        wr_reg(2'd3, 8'h03);
        rd_reg(2'd3, c);
        check("R8", "zero write keeps flag", {8'd0, c}, 16'h0013);
        wr_reg(2'd3, 8'h13);
        check("R10", "irq low after clear", {15'd0, host_irq}, 16'd0);
        rd_reg(2'd3, c);
        check("R8", "flag 0 cleared", {8'd0, c}, 16'h0003);
        @(negedge clk); int1_set = 1'b1;
        @(negedge clk); int1_set = 1'b0;
        check("R10", "irq on flag 1", {15'd0, host_irq}, 16'd1);
        rd_reg(2'd3, c);
        check("R8", "flag 1 bit 5", {8'd0, c}, 16'h0023);
        wr_reg(2'd3, 8'h23);
        check("R10", "irq low after flag 1 clear", {15'd0, host_irq}, 16'd0);
    endtask

    task automatic t_race;
        logic [7:0] c;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_reg = 2'd3; bus_wdata = 8'h33; int0_set = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; int0_set = 1'b0;
        rd_reg(2'd3, c);
        check("R9", "set beats clear", {8'd0, c}, 16'h0013);
        wr_reg(2'd3, 8'h10);
        rd_reg(2'd3, c);
        check("R9", "clear afterwards", {8'd0, c}, 16'h0000);
    endtask

    task automatic t_arb;
        logic [7:0] d;
        @(negedge clk);
        cp_req = 1'b1; cp_we = 1'b1; cp_addr = 10'h005; cp_wdata = 8'h5A;
        #1 check("R11", "grant when host idle", {15'd0, cp_gnt}, 16'd1);
        @(negedge clk); cp_req = 1'b0; cp_we = 1'b0;
        wr_reg(2'd3, 8'h00);
        set_ptr(16'h0005);
        rd_reg(2'd2, d);
        check("R11", "host sees coproc write", {8'd0, d}, 16'h005A);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_reg = 2'd2; bus_wdata = 8'h77;
        cp_req = 1'b1; cp_we = 1'b1; cp_addr = 10'h006; cp_wdata = 8'hEE;
        #1 check("R11", "no grant during host data access", {15'd0, cp_gnt}, 16'd0);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; cp_we = 1'b0; cp_addr = 10'h005;
        #1 check("R11", "grant after host access", {15'd0, cp_gnt}, 16'd1);
        @(negedge clk); cp_req = 1'b0;
        check("R11", "coproc read data", {8'd0, cp_rdata}, 16'h0077);
        set_ptr(16'h0006);
        rd_reg(2'd2, d);
        check("R11", "ungranted coproc write dropped", {8'd0, d}, 16'h0000);
    endtask

    initial begin
        #2_000_000;
        fails++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_reg = 2'd0; bus_wdata = 8'd0;
        cp_doorbell_ack = 1'b0; int0_set = 1'b0; int1_set = 1'b0;
        cp_req = 1'b0; cp_we = 1'b0; cp_addr = '0; cp_wdata = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Clear RAM byte 6 through the host so the dropped-write check is defined.
        t_reset;
        wr_reg(2'd3, 8'h00);
        set_ptr(16'h0006);
        wr_reg(2'd2, 8'h00);
        set_ptr(16'h0000);
        t_ptr_load;
        t_no_inc;
        t_inc;
        t_wrap;
        t_ctrl;
        t_doorbell;
        t_flags;
        t_race;
        t_arb;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule